// File: doc/BRIEF.md
# SDRAM Write Burst Termination Sequencer

This block sits inside an SDRAM controller and runs the command side of a write burst, including the case where a new READ, WRITE or PRECHARGE request arrives before the burst has finished. For each clock it chooses the command placed on the SDRAM command bus. It also drives the controller's data output enable and the per-byte data mask, and it reports through a busy flag when new requests cannot be taken.

Requests arrive as a one-cycle strobe with a kind, a bank and an all-banks flag. The configuration inputs are:

- the burst length;
- the CAS latency (2 or 3);
- the write-recovery time, the precharge time and the clock period, all in one common time unit.

The block divides the two times by the clock period, rounding up, to get the write-recovery cycle count m and the precharge cycle count rp. A result of 0 is treated as 1. The configuration is expected to change only while the block is idle.

Top module: `wr_term_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, the command is NOP (code 0), the output enable is low, the mask is low and busy is low.
- R2: A WRITE request (kind 0) taken in cycle c puts a WRITE command (code 3) with the request's bank in cycle c+1. The output enable is high for BL consecutive cycles from c+1, with beat index 0 to BL-1. BL is the configured burst length, with 0 treated as 1 and values above MAX_BL clamped to MAX_BL.
- R3: A WRITE request taken while a burst is running discards that burst's remaining beats. The new WRITE goes out in the next cycle and its beat index starts again at 0.
- R4: A READ request (kind 1) taken in cycle c puts a READ command (code 2) in cycle c+1. The output enable is low from c+1 until a later WRITE, the beats not yet sent are dropped, and the mask stays low.
- R5: Busy is high for CL cycles starting with the READ cycle. CL is 3 when the CAS-latency input equals 3 and 2 otherwise, so the drivers are off at least one cycle before read data can appear.
- R6: A PRECHARGE request (kind 2) taken in cycle c puts a PRECHARGE command (code 4) in cycle max(c+1, L+m), where L is the last cycle with the output enable high. m = max(1, ceil(tWR / max(tCK,1))). The all-banks flag and the bank of the request go out with it.
- R7: The mask is all ones from cycle c+1 through the PRECHARGE cycle inclusive, and the output enable is low over that span.
- R8: Busy is high from cycle c+1 through cycle P+rp-1, where P is the PRECHARGE cycle and rp = max(1, ceil(tRP / max(tCK,1))).
- R9: Requests that arrive while busy is high have no effect. An ACTIVATE request (kind 3) is taken only when busy is low and no beat is driven in that cycle, and its ACTIVATE (code 1) goes out in the next cycle. An ACTIVATE therefore never follows a PRECHARGE by fewer than rp cycles.
- R10: The command bus carries NOP (code 0) in every cycle in which none of the commands above is due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | 0 write, 1 read, 2 precharge, 3 activate |
| req_bank | input | BANK_W | Target bank |
| req_all | input | 1 | Precharge all banks |
| cfg_bl | input | $clog2(MAX_BL)+1 | Burst length in beats |
| cfg_cl | input | 2 | CAS latency (2 or 3) |
| cfg_twr | input | TW | Write-recovery time |
| cfg_trp | input | TW | Precharge time |
| cfg_tck | input | TW | Clock period, same unit |
| sd_cmd | output | 3 | Command code |
| sd_bank | output | BANK_W | Bank of the command |
| sd_all | output | 1 | All-banks flag of a precharge |
| dq_oe | output | 1 | Data output enable |
| dqm | output | DQM_W | Byte mask |
| beat_idx | output | $clog2(MAX_BL) | Index of the beat being driven |
| busy | output | 1 | Requests are not taken |

## Verification
A corrupted beat counter appears at once as a wrong beat index, or as an output enable that stays high or drops one cycle from where the burst length puts it. A wrong recovery count moves the PRECHARGE cycle and the end of the mask window within m cycles of the request. A stuck hold counter first shows as busy staying high too long. It then shows as an ACTIVATE or WRITE that fails to appear in the cycle after its request. Because the reference model predicts every output on every clock, each such fault is reported on the first cycle in which it differs.

// File: rtl/wts_pkg.sv
package wts_pkg;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_ACT   = 3'd1,
        CMD_READ  = 3'd2,
        CMD_WRITE = 3'd3,
        CMD_PRE   = 3'd4
    } sd_cmd_e;

    typedef enum logic [1:0] {
        RQ_WRITE = 2'd0,
        RQ_READ  = 2'd1,
        RQ_PRE   = 2'd2,
        RQ_ACT   = 2'd3
    } req_kind_e;

    // State names the content of the current cycle.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_PWAIT = 2'd2,
        ST_HOLD  = 2'd3
    } seq_st_e;

    typedef struct packed {
        sd_cmd_e cmd;
        logic    oe;
        logic    mask;
        logic    busy;
        logic    all;
    } drive_t;

endpackage

// File: rtl/wts_ceil_div.sv
module wts_ceil_div #(
    parameter int W = 8
) (
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic [W-1:0] quo
);
    logic [W:0] den_e;
    logic [W:0] sum;
    logic [W:0] raw;
    logic       unused_hi;

    always_comb begin
        den_e = (den == '0) ? (W+1)'(1) : {1'b0, den};
        sum   = {1'b0, num} + den_e - (W+1)'(1);
        raw   = sum / den_e;
        quo   = (raw == '0) ? W'(1) : raw[W-1:0];
    end

    assign unused_hi = raw[W];
endmodule

// File: rtl/wts_recovery.sv
module wts_recovery #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          beat_now,
    input  logic [TW-1:0] m_cyc,
    output logic          rec_clear_next
);
    logic [TW-1:0] rec_q;
    logic [TW-1:0] rec_d;

    always_comb begin
        if (beat_now)
            rec_d = m_cyc - TW'(1);
        else if (rec_q != '0)
            rec_d = rec_q - TW'(1);
        else
            rec_d = '0;
        rec_clear_next = (rec_d == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) rec_q <= '0;
        else     rec_q <= rec_d;
    end
endmodule

// File: rtl/wts_fsm.sv
module wts_fsm
    import wts_pkg::*;
#(
    parameter int BLW    = 4,
    parameter int IDXW   = 3,
    parameter int TW     = 8,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [BANK_W-1:0] req_bank,
    input  logic              req_all,
    input  logic [BLW-1:0]    bl_eff,
    input  logic              cl3,
    input  logic [TW-1:0]     rp_cyc,
    input  logic              rec_clear_next,
    output drive_t            drv,
    output logic [BANK_W-1:0] bank,
    output logic [IDXW-1:0]   beat
);
    seq_st_e           st_q, st_d;
    drive_t            drv_d;
    logic [BANK_W-1:0] bank_d;
    logic [IDXW-1:0]   beat_d;
    logic [BLW-1:0]    left_q, left_d;
    logic [TW-1:0]     hold_q, hold_d;
    logic              take;
    req_kind_e         kind;

    assign kind = req_kind_e'(req_kind);
    assign take = req_valid && (st_q == ST_IDLE || st_q == ST_BURST);

    always_comb begin
        st_d   = st_q;
        drv_d  = '{cmd: CMD_NOP, oe: 1'b0, mask: 1'b0, busy: 1'b0, all: drv.all};
        bank_d = bank;
        beat_d = beat;
        left_d = left_q;
        hold_d = hold_q;

        case (st_q)
            ST_BURST: begin
                if (left_q != '0) begin
                    drv_d.oe = 1'b1;
                    beat_d   = beat + IDXW'(1);
                    left_d   = left_q - BLW'(1);
                end else begin
                    st_d = ST_IDLE;
                end
            end
            ST_PWAIT: begin
                drv_d.mask = 1'b1;
                drv_d.busy = 1'b1;
                if (rec_clear_next) begin
                    st_d      = ST_HOLD;
                    drv_d.cmd = CMD_PRE;
                    hold_d    = rp_cyc - TW'(1);
                end
            end
            ST_HOLD: begin
                if (hold_q != '0) begin
                    drv_d.busy = 1'b1;
                    hold_d     = hold_q - TW'(1);
                end else begin
                    st_d = ST_IDLE;
                end
            end
            default: ;
        endcase

        if (take) begin
            case (kind)
                RQ_WRITE: begin
                    st_d      = ST_BURST;
                    drv_d.cmd = CMD_WRITE;
                    drv_d.oe  = 1'b1;
                    drv_d.all = 1'b0;
                    bank_d    = req_bank;
                    beat_d    = '0;
                    left_d    = bl_eff - BLW'(1);
                end
                RQ_READ: begin
                    st_d       = ST_HOLD;
                    drv_d.cmd  = CMD_READ;
                    drv_d.oe   = 1'b0;
                    drv_d.busy = 1'b1;
                    drv_d.all  = 1'b0;
                    bank_d     = req_bank;
                    hold_d     = cl3 ? TW'(2) : TW'(1);
                end
                RQ_PRE: begin
                    drv_d.oe   = 1'b0;
                    drv_d.mask = 1'b1;
                    drv_d.busy = 1'b1;
                    drv_d.all  = req_all;
                    bank_d     = req_bank;
                    if (rec_clear_next) begin
                        st_d      = ST_HOLD;
                        drv_d.cmd = CMD_PRE;
                        hold_d    = rp_cyc - TW'(1);
                    end else begin
                        st_d = ST_PWAIT;
                    end
                end
                default: begin
                    if (st_q == ST_IDLE) begin
                        drv_d.cmd = CMD_ACT;
                        drv_d.all = 1'b0;
                        bank_d    = req_bank;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            drv    <= '{cmd: CMD_NOP, oe: 1'b0, mask: 1'b0, busy: 1'b0, all: 1'b0};
            bank   <= '0;
            beat   <= '0;
            left_q <= '0;
            hold_q <= '0;
        end else begin
            st_q   <= st_d;
            drv    <= drv_d;
            bank   <= bank_d;
            beat   <= beat_d;
            left_q <= left_d;
            hold_q <= hold_d;
        end
    end
endmodule

// File: rtl/wr_term_seq.sv
module wr_term_seq
    import wts_pkg::*;
#(
    parameter int MAX_BL = 8,
    parameter int TW     = 8,
    parameter int BANK_W = 2,
    parameter int DQM_W  = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic [1:0]                  req_kind,
    input  logic [BANK_W-1:0]           req_bank,
    input  logic                        req_all,
    input  logic [$clog2(MAX_BL):0]     cfg_bl,
    input  logic [1:0]                  cfg_cl,
    input  logic [TW-1:0]               cfg_twr,
    input  logic [TW-1:0]               cfg_trp,
    input  logic [TW-1:0]               cfg_tck,
    output logic [2:0]                  sd_cmd,
    output logic [BANK_W-1:0]           sd_bank,
    output logic                        sd_all,
    output logic                        dq_oe,
    output logic [DQM_W-1:0]            dqm,
    output logic [$clog2(MAX_BL)-1:0]   beat_idx,
    output logic                        busy
);
    localparam int IDXW = $clog2(MAX_BL);
    localparam int BLW  = IDXW + 1;

    logic [TW-1:0]  m_cyc;
    logic [TW-1:0]  rp_cyc;
    logic [BLW-1:0] bl_eff;
    logic           rec_clear_next;
    drive_t         drv;

    always_comb begin
        if (cfg_bl == '0)
            bl_eff = BLW'(1);
        else if (cfg_bl > BLW'(MAX_BL))
            bl_eff = BLW'(MAX_BL);
        else
            bl_eff = cfg_bl;
    end

    wts_ceil_div #(.W(TW)) u_m_div (
        .num (cfg_twr),
        .den (cfg_tck),
        .quo (m_cyc)
    );

    wts_ceil_div #(.W(TW)) u_rp_div (
        .num (cfg_trp),
        .den (cfg_tck),
        .quo (rp_cyc)
    );

    wts_recovery #(.TW(TW)) u_rec (
        .clk            (clk),
        .rst            (rst),
        .beat_now       (drv.oe),
        .m_cyc          (m_cyc),
        .rec_clear_next (rec_clear_next)
    );

    wts_fsm #(
        .BLW    (BLW),
        .IDXW   (IDXW),
        .TW     (TW),
        .BANK_W (BANK_W)
    ) u_fsm (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_kind       (req_kind),
        .req_bank       (req_bank),
        .req_all        (req_all),
        .bl_eff         (bl_eff),
        .cl3            (cfg_cl == 2'd3),
        .rp_cyc         (rp_cyc),
        .rec_clear_next (rec_clear_next),
        .drv            (drv),
        .bank           (sd_bank),
        .beat           (beat_idx)
    );

    assign sd_cmd = drv.cmd;
    assign sd_all = drv.all;
    assign dq_oe  = drv.oe;
    assign busy   = drv.busy;
    assign dqm    = {DQM_W{drv.mask}};
endmodule

// File: rtl/wr_term_seq_chk.sv
module wr_term_seq_chk #(
    parameter int TW    = 8,
    parameter int IDXW  = 3,
    parameter int DQM_W = 4
) (
    input logic            clk,
    input logic            rst,
    input logic [2:0]      sd_cmd,
    input logic            dq_oe,
    input logic [DQM_W-1:0] dqm,
    input logic [IDXW-1:0] beat_idx,
    input logic            busy,
    input logic [TW-1:0]   m_cyc,
    input logic [TW-1:0]   rp_cyc
);
    logic [TW:0] gap_beat;
    logic [TW:0] gap_pre;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_beat <= '1;
            gap_pre  <= '1;
        end else begin
            gap_beat <= dq_oe ? (TW+1)'(1) : ((gap_beat == '1) ? gap_beat : gap_beat + 1'b1);
            gap_pre  <= (sd_cmd == 3'd4) ? (TW+1)'(1) : ((gap_pre == '1) ? gap_pre : gap_pre + 1'b1);
        end
    end

    a_r2_oe_starts_with_write: assert property (@(posedge clk) disable iff (rst)
        $rose(dq_oe) |-> (sd_cmd == 3'd3));

    a_r3_write_restarts_beat: assert property (@(posedge clk) disable iff (rst)
        (sd_cmd == 3'd3) |-> (dq_oe && beat_idx == '0));

    a_r4_read_drivers_off: assert property (@(posedge clk) disable iff (rst)
        (sd_cmd == 3'd2) |-> (!dq_oe && dqm == '0));

    a_r5_read_busy: assert property (@(posedge clk) disable iff (rst)
        (sd_cmd == 3'd2) |-> busy);

    a_r6_write_recovery: assert property (@(posedge clk) disable iff (rst)
        (sd_cmd == 3'd4) |-> (gap_beat >= {1'b0, m_cyc}));

    a_r7_pre_masked: assert property (@(posedge clk) disable iff (rst)
        (sd_cmd == 3'd4) |-> (dqm == '1 && !dq_oe));

    a_r9_act_after_rp: assert property (@(posedge clk) disable iff (rst)
        (sd_cmd == 3'd1) |-> (gap_pre >= {1'b0, rp_cyc}));
endmodule

bind wr_term_seq wr_term_seq_chk #(
    .TW    (TW),
    .IDXW  ($clog2(MAX_BL)),
    .DQM_W (DQM_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sd_cmd   (sd_cmd),
    .dq_oe    (dq_oe),
    .dqm      (dqm),
    .beat_idx (beat_idx),
    .busy     (busy),
    .m_cyc    (m_cyc),
    .rp_cyc   (rp_cyc)
);

// File: tb/test_wr_term_seq.sv
`timescale 1ns/1ps
module test_wr_term_seq;
    localparam int MAX_BL = 8;
    localparam int TW     = 8;
    localparam int BANK_W = 2;
    localparam int DQM_W  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rq_v = 1'b0;
    logic [1:0] rq_kind = '0;
    logic [BANK_W-1:0] rq_bank = '0;
    logic rq_all = 1'b0;
    logic [3:0] cfg_bl = 4'd4;
    logic [1:0] cfg_cl = 2'd2;
    logic [TW-1:0] cfg_twr = 8'd15;
    logic [TW-1:0] cfg_trp = 8'd20;
    logic [TW-1:0] cfg_tck = 8'd7;

    logic [2:0] sd_cmd;
    logic [BANK_W-1:0] sd_bank;
    logic sd_all, dq_oe, busy;
    logic [DQM_W-1:0] dqm;
    logic [2:0] beat_idx;

    wr_term_seq #(.MAX_BL(MAX_BL), .TW(TW), .BANK_W(BANK_W), .DQM_W(DQM_W)) i_wr_term_seq (
        .clk(clk), .rst(rst), .req_valid(rq_v), .req_kind(rq_kind), .req_bank(rq_bank),
        .req_all(rq_all), .cfg_bl(cfg_bl), .cfg_cl(cfg_cl), .cfg_twr(cfg_twr),
        .cfg_trp(cfg_trp), .cfg_tck(cfg_tck), .sd_cmd(sd_cmd), .sd_bank(sd_bank),
        .sd_all(sd_all), .dq_oe(dq_oe), .dqm(dqm), .beat_idx(beat_idx), .busy(busy)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string scen = "R1";

    // Reference model: event cycles on an integer timeline.
    int cyc = 0;
    int wr_start = -100, wr_stop = -200, wr_bank = 0;
    int rd_at = -100, rd_bank = 0;
    int pre_req = -100, pre_at = -100, pre_bank = 0, pre_all = 0;
    int act_at = -100, act_bank = 0;
    int lastbeat = -1000;

    function automatic int ceil_min1(int t, int ck);
        int d = (ck == 0) ? 1 : ck;
        int q = (t + d - 1) / d;
        return (q == 0) ? 1 : q;
    endfunction
    function automatic int m_e();  return ceil_min1(cfg_twr, cfg_tck); endfunction
    function automatic int rp_e(); return ceil_min1(cfg_trp, cfg_tck); endfunction
    function automatic int cl_e(); return (cfg_cl == 2'd3) ? 3 : 2; endfunction
    function automatic int bl_e();
        if (cfg_bl == 0) return 1;
        if (cfg_bl > MAX_BL) return MAX_BL;
        return cfg_bl;
    endfunction
    function automatic bit oe_e(int c);   return c >= wr_start && c <= wr_stop; endfunction
    function automatic bit dqm_e(int c);  return c >= pre_req + 1 && c <= pre_at; endfunction
    function automatic bit busy_e(int c);
        return (c >= rd_at && c <= rd_at + cl_e() - 1) ||
               (c >= pre_req + 1 && c <= pre_at + rp_e() - 1);
    endfunction
    function automatic int cmd_e(int c);
        if (c == wr_start) return 3;
        if (c == rd_at)    return 2;
        if (c == pre_at)   return 4;
        if (c == act_at)   return 1;
        return 0;
    endfunction
    function automatic int bank_e(int c);
        if (c == wr_start) return wr_bank;
        if (c == rd_at)    return rd_bank;
        if (c == pre_at)   return pre_bank;
        return act_bank;
    endfunction

    task automatic check(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s [%s] cycle %0d: got %0d expected %0d", scen, tag, cyc, got, exp);
        end
    endtask

    task automatic compare();
        int ec = cmd_e(cyc);
        check("R10 cmd", int'(sd_cmd), ec);
        check("R2 oe", int'(dq_oe), int'(oe_e(cyc)));
        if (oe_e(cyc)) check("R3 beat", int'(beat_idx), (cyc - wr_start) % MAX_BL);
        check("R7 dqm", int'(dqm), dqm_e(cyc) ? 15 : 0);
        check("R8 busy", int'(busy), int'(busy_e(cyc)));
        if (ec != 0) begin
            check("R2 bank", int'(sd_bank), bank_e(cyc));
            check("R6 all", int'(sd_all), (ec == 4) ? pre_all : 0);
        end
    endtask

    task automatic model_step();
        if (oe_e(cyc)) lastbeat = cyc;
        if (rq_v && !busy_e(cyc)) begin
            case (rq_kind)
                2'd0: begin wr_start = cyc + 1; wr_stop = cyc + bl_e(); wr_bank = rq_bank; end
                2'd1: begin rd_at = cyc + 1; rd_bank = rq_bank; if (wr_stop > cyc) wr_stop = cyc; end
                2'd2: begin
                    pre_req = cyc;
                    pre_at  = (lastbeat + m_e() > cyc + 1) ? lastbeat + m_e() : cyc + 1;
                    pre_bank = rq_bank; pre_all = rq_all;
                    if (wr_stop > cyc) wr_stop = cyc;
                end
                default: if (!oe_e(cyc)) begin act_at = cyc + 1; act_bank = rq_bank; end
            endcase
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        cyc++;
        compare();
    endtask

    task automatic idle(int n);
        repeat (n) tick();
    endtask

    task automatic req(int kind, int bank, bit all);
        rq_v = 1'b1; rq_kind = 2'(kind); rq_bank = BANK_W'(bank); rq_all = all;
        tick();
        rq_v = 1'b0; rq_all = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        scen = "R1 reset";
        check("R1 cmd", int'(sd_cmd), 0);
        check("R1 oe", int'(dq_oe), 0);
        check("R1 busy", int'(busy), 0);
        rst = 1'b0;
        cyc = 0;
        compare();
        idle(2);

        scen = "R2 full burst";
        req(0, 1, 0); idle(6);

        scen = "R3 write over write";
        req(0, 2, 0); idle(1); req(0, 3, 0); idle(6);

        scen = "R4 R5 read cl2";
        req(0, 0, 0); idle(1); req(1, 2, 0); idle(6);

        scen = "R5 read cl3";
        cfg_cl = 2'd3;
        req(0, 1, 0); req(1, 1, 0); idle(6);

        scen = "R4 read bl2";
        cfg_bl = 4'd2;
        req(0, 3, 0); req(1, 0, 0); idle(6);
        cfg_bl = 4'd4; cfg_cl = 2'd2;

        scen = "R6 R7 R8 R9 precharge in burst";
        req(0, 2, 0); idle(1); req(2, 2, 0);
        req(0, 1, 0); req(1, 1, 0);
        repeat (10) req(3, 2, 0);
        idle(4);

        scen = "R6 precharge all after burst end";
        cfg_bl = 4'd1;
        req(0, 1, 0); req(2, 0, 1); repeat (8) req(3, 1, 0); idle(3);

        scen = "R6 precharge long after burst";
        req(2, 3, 0); idle(6);

        scen = "R6 R8 zero times";
        cfg_twr = 8'd0; cfg_trp = 8'd0; cfg_tck = 8'd0; cfg_bl = 4'd4;
        idle(2);
        req(0, 1, 0); idle(1); req(2, 1, 0); req(3, 1, 0); idle(4);

        scen = "R9 act during burst";
        cfg_twr = 8'd30; cfg_trp = 8'd9; cfg_tck = 8'd4;
        idle(2);
        req(0, 2, 0); req(3, 2, 0); idle(5); req(3, 0, 0); idle(2);
        req(0, 0, 0); idle(3); req(2, 0, 0); idle(12);

        scen = "R2 bl zero";
        cfg_bl = 4'd0;
        req(0, 1, 0); idle(4);

        scen = "R2 bl clamp";
        cfg_bl = 4'd15;
        req(0, 2, 0); idle(11);

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule